// File: doc/BRIEF.md
# Multi-Peripheral SPI Master with Per-Target Timing

This block is a master-only SPI controller for an on-chip register bus. The host programs a control register, a mode register and four per-target timing registers. It then writes bytes into a transmit buffer. Each byte is shifted out MSB first in SPI mode 0, while the byte clocked in on MISO is stored with the chip-select pattern that was active during the transfer.

The target of a transfer can come from one of two places. It can be fixed in the mode register, or it can travel with each written byte. The chip-select lines can be driven as a one-hot active-low select, or they can carry the raw 4-bit code for an external decoder. The selected target's timing register sets three things:

- the SPCK rate,
- the delay from chip-select assertion to the first clock edge,
- the idle time with all selects high between back-to-back transfers.

A separate active-low sense input reports another master claiming the bus. When that happens, the block aborts the transfer, disables itself and flags a mode fault.

Top module: `spi_pcs_master`

## Requirements
- R1: After reset, npcs_o is 4'b1111, spck_o and mosi_o are 0, tx_empty_o is 1, and rx_full_o, ovr_o, modf_o and en_o are 0.
- R2: While enabled, a write to address 2 (bits [7:0] = byte, bits [11:8] = per-word target code) starts an 8-bit transfer. SPCK idles low. MOSI carries the byte MSB first and changes only after falling edges. MISO is sampled on rising edges. The received byte appears in bits [7:0] of address 3.
- R3: With mode register (address 1) bit 0 = 0, the target code is mode bits [7:4] for every transfer, and the code in the transmit word is ignored.
- R4: With mode bit 0 = 1, the target code is bits [11:8] of each transmit word, mode bits [7:4] are ignored, and the transfer uses the timing register of that target.
- R5: With mode bit 1 = 0 (direct), only the output at the lowest-numbered zero bit of the code is driven low during the transfer, and that bit number selects the timing register. Code 4'b1111 drives no select low and uses timing register 0.
- R6: With mode bit 1 = 1 (encoded), npcs_o equals the code during the transfer, and code bits [1:0] select the timing register.
- R7: Timing register n sits at address 8+n, with bits [7:0] = divider D, bits [15:8] = setup S and bits [23:16] = gap G. From the select assertion to the first SPCK rise there are S+D+2 clock cycles. The SPCK period is 2*(D+1) cycles. Between back-to-back transfers, npcs_o stays 4'b1111 for G+2 cycles.
- R8: npcs_o is 4'b1111 outside transfers. Bits [11:8] of address 3 hold the npcs_o value used by the last completed transfer.
- R9: A word written while a transfer runs is taken when the current transfer and its gap end, and it is sent without host action. tx_empty_o (status bit 0) rises when the buffered word is taken.
- R10: A completed transfer sets rx_full_o (status bit 1), and a read of address 3 clears it. A transfer that completes while rx_full_o is already set also sets ovr_o (status bit 2), and a read of the status register (address 4) clears it.
- R11: While the block is enabled, ss_ni low causes three things within four cycles: modf_o (status bit 3) rises, en_o (status bit 4) falls, and the transfer aborts with npcs_o at 4'b1111 and SPCK low. A status read clears modf_o. The block starts no transfer until control bit 0 is written again.
- R12: Control register (address 0) bit 0 = 1 enables the block, and bit 1 = 1 disables it (bit 1 wins). While disabled, a buffered word is held and not sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (read side effects) |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the current address |
| spck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| npcs_o | output | 4 | Chip-select lines, active low or encoded |
| ss_ni | input | 1 | External master bus-claim sense, active low |
| tx_empty_o | output | 1 | Transmit buffer empty |
| rx_full_o | output | 1 | Receive register holds unread data |
| ovr_o | output | 1 | Receive overrun flag |
| modf_o | output | 1 | Mode fault flag |
| en_o | output | 1 | Block enabled |

## Verification
The hardest state to reach is a bus claim that lands in the middle of a shift, after SPCK has started toggling. The stimulus therefore waits for the first observed SPCK rise of a slow transfer before pulling ss_ni low. It then checks the abort, the latched fault and the held-off restart. Back-to-back overlap is also hard to arrange. The stimulus writes the second word the moment tx_empty_o reports that the first word was taken. It leaves the receive register unread, so that a single sequence exercises the gap timing, the automatic follow-on and the overrun.

// File: rtl/spi_pcs_pkg.sv
`timescale 1ns/1ps
package spi_pcs_pkg;
  localparam int ADDR_W = 4;
  localparam int REG_W  = 32;
  localparam int CNT_W  = 8;

  typedef struct packed {
    logic [CNT_W-1:0] gap;
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] div;
  } cs_cfg_t;

  localparam int CFG_W = $bits(cs_cfg_t);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_SHIFT, ST_GAP} eng_state_e;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 4'd1;
  localparam logic [ADDR_W-1:0] A_TDR  = 4'd2;
  localparam logic [ADDR_W-1:0] A_RDR  = 4'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd4;
  localparam logic [ADDR_W-1:0] A_CSR0 = 4'd8;
endpackage

// File: rtl/spi_pcs_regs.sv
`timescale 1ns/1ps
module spi_pcs_regs
  import spi_pcs_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              ps_o,
  output logic              pcsdec_o,
  output logic [NUM_CS-1:0] mode_pcs_o,
  output cs_cfg_t           cfg_o [NUM_CS],
  output logic              en_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic [NUM_CS-1:0] tx_pcs_o,
  input  logic              tx_take_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic [NUM_CS-1:0] rx_npcs_i,
  input  logic              fault_i,
  output logic              rx_full_o,
  output logic              ovr_o,
  output logic              modf_o
);
  localparam int PCS_LSB = 8;
  localparam int MPCS_LSB = 4;

  logic              en_q, ps_q, pcsdec_q, tx_valid_q, rx_full_q, ovr_q, modf_q;
  logic [NUM_CS-1:0] mode_pcs_q, tx_pcs_q, rx_npcs_q;
  logic [DATA_W-1:0] tx_data_q, rx_q;

  logic wr_ctrl, wr_mode, wr_tdr, rd_rdr, rd_stat;
  assign wr_ctrl = wr_i && addr_i == A_CTRL;
  assign wr_mode = wr_i && addr_i == A_MODE;
  assign wr_tdr  = wr_i && addr_i == A_TDR;
  assign rd_rdr  = rd_i && addr_i == A_RDR;
  assign rd_stat = rd_i && addr_i == A_STAT;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[REG_W-1:CFG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      modf_q     <= 1'b0;
      ps_q       <= 1'b0;
      pcsdec_q   <= 1'b0;
      mode_pcs_q <= '1;
    end else begin
      if (fault_i)                  en_q <= 1'b0;
      else if (wr_ctrl && wdata_i[1]) en_q <= 1'b0;
      else if (wr_ctrl && wdata_i[0]) en_q <= 1'b1;
      if (fault_i)      modf_q <= 1'b1;
      else if (rd_stat) modf_q <= 1'b0;
      if (wr_mode) begin
        ps_q       <= wdata_i[0];
        pcsdec_q   <= wdata_i[1];
        mode_pcs_q <= wdata_i[MPCS_LSB +: NUM_CS];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
      tx_pcs_q   <= '1;
    end else if (wr_tdr) begin
      tx_valid_q <= 1'b1;
      tx_data_q  <= wdata_i[DATA_W-1:0];
      tx_pcs_q   <= wdata_i[PCS_LSB +: NUM_CS];
    end else if (tx_take_i) begin
      tx_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_full_q <= 1'b0;
      ovr_q     <= 1'b0;
      rx_q      <= '0;
      rx_npcs_q <= '1;
    end else begin
      ovr_q <= (ovr_q && !rd_stat) || (done_i && rx_full_q && !rd_rdr);
      if (done_i) begin
        rx_full_q <= 1'b1;
        rx_q      <= rx_data_i;
        rx_npcs_q <= rx_npcs_i;
      end else if (rd_rdr) begin
        rx_full_q <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_csr
    cs_cfg_t cfg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q <= '0;
      else if (wr_i && addr_i == ADDR_W'(32'(A_CSR0) + g)) cfg_q <= cs_cfg_t'(wdata_i[CFG_W-1:0]);
    end
    assign cfg_o[g] = cfg_q;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: rdata_o[0] = en_q;
      A_MODE: begin
        rdata_o[0] = ps_q;
        rdata_o[1] = pcsdec_q;
        rdata_o[MPCS_LSB +: NUM_CS] = mode_pcs_q;
      end
      A_RDR: begin
        rdata_o[DATA_W-1:0] = rx_q;
        rdata_o[PCS_LSB +: NUM_CS] = rx_npcs_q;
      end
      A_STAT: rdata_o[4:0] = {en_q, modf_q, ovr_q, rx_full_q, !tx_valid_q};
      default: begin
        for (int i = 0; i < NUM_CS; i++)
          if (addr_i == ADDR_W'(32'(A_CSR0) + i)) rdata_o[CFG_W-1:0] = cfg_o[i];
      end
    endcase
  end

  assign en_o       = en_q;
  assign ps_o       = ps_q;
  assign pcsdec_o   = pcsdec_q;
  assign mode_pcs_o = mode_pcs_q;
  assign tx_valid_o = tx_valid_q;
  assign tx_data_o  = tx_data_q;
  assign tx_pcs_o   = tx_pcs_q;
  assign rx_full_o  = rx_full_q;
  assign ovr_o      = ovr_q;
  assign modf_o     = modf_q;

  AST_TAKE_HAS_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_take_i |-> tx_valid_q); // R9
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(rx_full_q) && $past(done_i)); // R10
  AST_FAULT_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(modf_q) |-> !en_q); // R11
endmodule

// File: rtl/spi_pcs_sel.sv
`timescale 1ns/1ps
module spi_pcs_sel
  import spi_pcs_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic              ps_i,
  input  logic              pcsdec_i,
  input  logic [NUM_CS-1:0] mode_pcs_i,
  input  logic [NUM_CS-1:0] tx_pcs_i,
  input  cs_cfg_t           cfg_i [NUM_CS],
  output logic [NUM_CS-1:0] pat_o,
  output cs_cfg_t           cfg_o
);
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic [NUM_CS-1:0] code, pat_dir;
  logic [IDX_W-1:0]  idx_dir, idx;

  assign code = ps_i ? tx_pcs_i : mode_pcs_i;

  // lowest zero wins; lines above it stay high
  for (genvar g = 0; g < NUM_CS; g++) begin : g_dir
    if (g == 0) begin : g_lsb
      assign pat_dir[g] = code[0];
    end else begin : g_up
      assign pat_dir[g] = code[g] | ~(&code[g-1:0]);
    end
  end

  always_comb begin
    idx_dir = '0;
    for (int i = NUM_CS - 1; i >= 0; i--)
      if (!code[i]) idx_dir = IDX_W'(i);
  end

  assign idx   = pcsdec_i ? code[IDX_W-1:0] : idx_dir;
  assign pat_o = pcsdec_i ? code : pat_dir;
  assign cfg_o = cfg_i[idx];
endmodule

// File: rtl/spi_pcs_engine.sv
`timescale 1ns/1ps
module spi_pcs_engine
  import spi_pcs_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [NUM_CS-1:0] pat_i,
  input  cs_cfg_t           cfg_i,
  input  logic              miso_i,
  output logic              take_o,
  output logic              spck_o,
  output logic              mosi_o,
  output logic [NUM_CS-1:0] npcs_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o,
  output logic [NUM_CS-1:0] rx_npcs_o
);
  localparam int EDGE_W = $clog2(2 * DATA_W);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * DATA_W - 1);

  eng_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [EDGE_W-1:0] edge_q;
  logic              spck_q, done_q;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q;
  logic [NUM_CS-1:0] pat_q;
  cs_cfg_t           cfg_q;
  logic              busy;

  assign take_o = state_q == ST_IDLE && start_i && !abort_i;
  assign busy   = state_q == ST_SETUP || state_q == ST_SHIFT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      edge_q  <= '0;
      spck_q  <= 1'b0;
      done_q  <= 1'b0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      pat_q   <= '1;
      cfg_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        state_q <= ST_IDLE;
        spck_q  <= 1'b0;
        cnt_q   <= '0;
      end else begin
        case (state_q)
          ST_IDLE: if (start_i) begin
            tx_sh_q <= data_i;
            pat_q   <= pat_i;
            cfg_q   <= cfg_i;
            cnt_q   <= cfg_i.setup;
            state_q <= ST_SETUP;
          end
          ST_SETUP: if (cnt_q == '0) begin
            cnt_q   <= cfg_q.div;
            edge_q  <= '0;
            state_q <= ST_SHIFT;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
          ST_SHIFT: if (cnt_q == '0) begin
            cnt_q  <= cfg_q.div;
            spck_q <= !spck_q;
            edge_q <= edge_q + 1'b1;
            if (!spck_q) rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso_i};
            else         tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
            if (edge_q == LAST_EDGE) begin
              cnt_q   <= cfg_q.gap;
              done_q  <= 1'b1;
              state_q <= ST_GAP;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
          default: if (cnt_q == '0) state_q <= ST_IDLE;
                   else             cnt_q   <= cnt_q - 1'b1;
        endcase
      end
    end
  end

  assign spck_o    = spck_q;
  assign mosi_o    = busy ? tx_sh_q[DATA_W-1] : 1'b0;
  assign npcs_o    = busy ? pat_q : '1;
  assign done_o    = done_q;
  assign rx_o      = rx_sh_q;
  assign rx_npcs_o = pat_q;

  AST_SPCK_ONLY_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_SHIFT |-> !spck_q); // R2
  AST_DONE_FROM_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(state_q) == ST_SHIFT && !spck_q); // R2
  AST_ABORT_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> state_q == ST_IDLE && npcs_o == '1); // R11
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spck_q) |-> $stable(mosi_o)); // R2
endmodule

// File: rtl/spi_pcs_master.sv
`timescale 1ns/1ps
module spi_pcs_master
  import spi_pcs_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              spck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] npcs_o,
  input  logic              ss_ni,
  output logic              tx_empty_o,
  output logic              rx_full_o,
  output logic              ovr_o,
  output logic              modf_o,
  output logic              en_o
);
  logic              ps, pcsdec, en, tx_valid, take, done, fault;
  logic [NUM_CS-1:0] mode_pcs, tx_pcs, pat, rx_npcs;
  logic [DATA_W-1:0] tx_data, rx_data;
  cs_cfg_t           cfg_all [NUM_CS];
  cs_cfg_t           cfg_sel;
  logic [1:0]        ss_sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ss_sync_q <= 2'b11;
    else         ss_sync_q <= {ss_sync_q[0], ss_ni};
  end
  assign fault = en && !ss_sync_q[1];

  spi_pcs_regs #(.NUM_CS(NUM_CS), .DATA_W(DATA_W)) regs_i (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .rd_i(reg_rd_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .ps_o(ps), .pcsdec_o(pcsdec), .mode_pcs_o(mode_pcs), .cfg_o(cfg_all),
    .en_o(en), .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_pcs_o(tx_pcs),
    .tx_take_i(take), .done_i(done), .rx_data_i(rx_data), .rx_npcs_i(rx_npcs),
    .fault_i(fault), .rx_full_o(rx_full_o), .ovr_o(ovr_o), .modf_o(modf_o)
  );

  spi_pcs_sel #(.NUM_CS(NUM_CS)) sel_i (
    .ps_i(ps), .pcsdec_i(pcsdec), .mode_pcs_i(mode_pcs), .tx_pcs_i(tx_pcs),
    .cfg_i(cfg_all), .pat_o(pat), .cfg_o(cfg_sel)
  );

  spi_pcs_engine #(.NUM_CS(NUM_CS), .DATA_W(DATA_W)) eng_i (
    .clk_i, .rst_ni,
    .start_i(en && tx_valid), .abort_i(fault || !en),
    .data_i(tx_data), .pat_i(pat), .cfg_i(cfg_sel), .miso_i,
    .take_o(take), .spck_o, .mosi_o, .npcs_o,
    .done_o(done), .rx_o(rx_data), .rx_npcs_o(rx_npcs)
  );

  assign tx_empty_o = !tx_valid;
  assign en_o       = en;

  AST_DIRECT_ONE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pcsdec |-> $countones(~pat) <= 1); // R5
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en && !$past(en) |-> npcs_o == '1 && !spck_o); // R12
endmodule

// File: tb/spi_pcs_master_tb_top.sv
`timescale 1ns/1ps
module spi_pcs_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        spck, mosi, miso, ss_n = 1'b1;
  logic [3:0]  npcs;
  logic        tx_empty, rx_full, ovr, modf, en;

  always #5 clk = ~clk;

  spi_pcs_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .spck_o(spck), .mosi_o(mosi),
    .miso_i(miso), .npcs_o(npcs), .ss_ni(ss_n), .tx_empty_o(tx_empty),
    .rx_full_o(rx_full), .ovr_o(ovr), .modf_o(modf), .en_o(en)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] miso_byte(input int k);
    return 8'((k * 53 + 17) & 255);
  endfunction

  function automatic logic [7:0] tx_byte(input int k);
    return 8'((k * 29 + 3) & 255);
  endfunction

  function automatic logic [3:0] exp_pat(input logic [3:0] p, input bit dec);
    if (dec) return p;
    for (int j = 0; j < 4; j++) if (!p[j]) return ~(4'b1 << j);
    return 4'hf;
  endfunction

  function automatic int exp_idx(input logic [3:0] p, input bit dec);
    if (dec) return int'(p[1:0]);
    for (int j = 0; j < 4; j++) if (!p[j]) return j;
    return 0;
  endfunction

  // timing set n: div=n, setup=2+n, gap=1+2n
  function automatic int cdiv(input int n);   return n;         endfunction
  function automatic int csetup(input int n); return 2 + n;     endfunction
  function automatic int cgap(input int n);   return 1 + 2 * n; endfunction

  // slave model
  int          rise_n = 0;
  logic [7:0]  cap = '0;
  logic [7:0]  mosi_log [256];
  logic [3:0]  npcs_log [256];
  time         t_r0 [256];
  time         t_r1 [256];
  time         t_as = 0, t_de = 0;
  logic [3:0]  npcs_prev = 4'hf;

  always_comb begin
    logic [7:0] b;
    b = miso_byte(rise_n / 8);
    miso = b[7 - (rise_n % 8)];
  end

  always @(posedge spck) begin
    int i, b;
    i = (rise_n / 8) % 256;
    b = rise_n % 8;
    cap = {cap[6:0], mosi};
    if (b == 0) begin t_r0[i] = $time; npcs_log[i] = npcs; end
    if (b == 1) t_r1[i] = $time;
    if (b == 7) mosi_log[i] = cap;
    rise_n = rise_n + 1;
  end

  always @(npcs) begin
    if (npcs_prev == 4'hf && npcs != 4'hf) t_as = $time;
    if (npcs_prev != 4'hf && npcs == 4'hf) t_de = $time;
    npcs_prev = npcs;
  end

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wait_rx();
    while (!rx_full) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    int k;
    k = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(npcs == 4'hf && !spck && !mosi, "R1 pins", {npcs, spck, mosi}, 'h3c);
    chk(tx_empty && !rx_full && !ovr && !modf && !en, "R1 flags",
        {tx_empty, rx_full, ovr, modf, en}, 'h10);

    for (int n = 0; n < 4; n++)
      reg_write(4'(8 + n), {8'h0, 8'(cgap(n)), 8'(csetup(n)), 8'(cdiv(n))});
    reg_read(4'd10, d);
    chk(d[23:0] == {8'(cgap(2)), 8'(csetup(2)), 8'(cdiv(2))}, "R7 timing reg", d, 0);
    reg_write(4'd0, 32'h1);
    chk(en, "R12 enable", en, 1);

    // sweep: decode mode x selection mode x every target code
    for (int dec = 0; dec < 2; dec++) begin
      for (int ps = 0; ps < 2; ps++) begin
        for (int p = 0; p < 16; p++) begin
          logic [3:0] pc, ep;
          int ix;
          string rq;
          pc = 4'(p);
          ep = exp_pat(pc, dec[0]);
          ix = exp_idx(pc, dec[0]);
          rq = ps ? "R4" : "R3";
          if (ps == 0) begin
            reg_write(4'd1, {24'h0, pc, 2'b0, 1'b1 * dec[0], 1'b0});
            reg_write(4'd2, {20'h0, ~pc, tx_byte(k)});
          end else begin
            reg_write(4'd1, {24'h0, ~pc, 2'b0, dec[0], 1'b1});
            reg_write(4'd2, {20'h0, pc, tx_byte(k)});
          end
          wait_rx();
          reg_read(4'd3, d);
          chk(mosi_log[k] == tx_byte(k), "R2 mosi byte", mosi_log[k], tx_byte(k));
          chk(d[7:0] == miso_byte(k), "R2 rdr byte", d[7:0], miso_byte(k));
          chk(d[11:8] == ep, "R8 rdr select", d[11:8], ep);
          chk(npcs_log[k] == ep, dec ? "R6 select lines" : "R5 select lines", npcs_log[k], ep);
          chk(npcs_log[k] == ep, rq, npcs_log[k], ep);
          chk(int'((t_r1[k] - t_r0[k]) / 10) == 2 * (cdiv(ix) + 1), "R4 R7 spck period",
              int'((t_r1[k] - t_r0[k]) / 10), 2 * (cdiv(ix) + 1));
          if (ep != 4'hf)
            chk(int'((t_r0[k] - t_as) / 10) == csetup(ix) + cdiv(ix) + 2, "R7 setup",
                int'((t_r0[k] - t_as) / 10), csetup(ix) + cdiv(ix) + 2);
          @(negedge clk);
          chk(!rx_full && !ovr, "R10 read clears full", {rx_full, ovr}, 0);
          k++;
        end
      end
    end

    // back-to-back with overrun: code 4'b1011 direct -> target 2
    begin
      time td, ta;
      reg_write(4'd1, 32'h1);
      reg_write(4'd2, {20'h0, 4'b1011, tx_byte(k)});
      while (!tx_empty) @(negedge clk);
      chk(tx_empty, "R9 taken", tx_empty, 1);
      reg_write(4'd2, {20'h0, 4'b1011, tx_byte(k + 1)});
      chk(!tx_empty, "R9 buffered", tx_empty, 0);
      wait_rx();
      td = t_de;
      while (npcs == 4'hf) @(negedge clk);
      ta = t_as;
      chk(int'((ta - td) / 10) == cgap(2) + 2, "R7 R9 gap", int'((ta - td) / 10), cgap(2) + 2);
      while (!ovr) @(negedge clk);
      chk(rx_full && ovr, "R10 overrun", {rx_full, ovr}, 3);
      chk(mosi_log[k + 1] == tx_byte(k + 1), "R9 second byte", mosi_log[k + 1], tx_byte(k + 1));
      reg_read(4'd3, d);
      chk(d[7:0] == miso_byte(k + 1), "R10 newest kept", d[7:0], miso_byte(k + 1));
      reg_read(4'd4, d);
      chk(d[2] == 1'b1, "R10 status ovr", d[2], 1);
      @(negedge clk);
      chk(!ovr && !rx_full, "R10 ovr cleared", {rx_full, ovr}, 0);
      k += 2;
    end

    // disabled block holds its word
    begin
      int r0;
      reg_write(4'd0, 32'h3);
      chk(!en, "R12 disable wins", en, 0);
      r0 = rise_n;
      reg_write(4'd2, {20'h0, 4'b1110, tx_byte(k)});
      repeat (40) @(negedge clk);
      chk(npcs == 4'hf && rise_n == r0 && !tx_empty, "R12 held",
          {npcs, 4'(rise_n - r0), 3'b0, tx_empty}, 'hf00);
      reg_write(4'd0, 32'h1);
      wait_rx();
      reg_read(4'd3, d);
      chk(d[7:0] == miso_byte(k) && mosi_log[k] == tx_byte(k), "R12 resumes", d[7:0], miso_byte(k));
      k++;
    end

    // bus claim in mid shift
    reg_write(4'd1, 32'h1);
    reg_write(4'd2, {20'h0, 4'b0111, tx_byte(k)});
    @(posedge spck);
    @(negedge clk);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(modf && !en, "R11 fault", {modf, en}, 2);
    chk(npcs == 4'hf && !spck, "R11 abort", {npcs, spck}, 'h1e);
    ss_n = 1'b1;
    repeat (3) @(negedge clk);
    reg_read(4'd4, d);
    chk(d[3] && !d[4], "R11 status", d[4:3], 1);
    @(negedge clk);
    chk(!modf && !en, "R11 clear", {modf, en}, 0);
    reg_write(4'd2, {20'h0, 4'b0111, tx_byte(k)});
    repeat (30) @(negedge clk);
    chk(npcs == 4'hf && !tx_empty && !rx_full, "R11 stays off", {npcs, tx_empty, rx_full}, 'h3c);
    reg_write(4'd0, 32'h1);
    wait_rx();
    chk(rx_full && en && !modf, "R11 restart", {rx_full, en, modf}, 6);
    summary();
  end
endmodule